// File: doc/BRIEF.md
# MEI Load/Store Coherency Sequencer

This block makes the processor-side coherency decision for one data-cache access at a time. The cache is write-back, cacheable and coherent, and each line is tracked in one of three states: modified, exclusive or invalid. For each load or store the block takes the current state of the addressed line and chooses one of three actions. It serves the access locally, it issues a bus read, or it issues a read-with-intent-to-modify. A store through a write-through mapping that lands on a modified line is handled by pushing the line out to memory first. The block then writes back the line's final state and pulses a completion signal.

While an access waits on the bus, the block stalls new requests. An address-retry response on the bus reissues the same operation unchanged. On a read fill the block also shows which of the ways is being refilled. It keeps a single reservation flag: a load-with-reserve sets it, and a conditional store or a block-zero clears it. The choice of the victim way and the movement of cast-out data belong to neighbouring logic.

Top module: `mei_ls_ctrl`

## Requirements
- R1: After reset, req_ready is 1 and bus_req, done, state_we, fill_way_vld and resv_valid are 0, with new_state reading invalid (00).
- R2: A load (req_op 000) or load-with-reserve (010) to a line in exclusive (01) or modified (10) starts no bus operation. done is raised on the cycle after acceptance, and new_state equals the original state.
- R3: A load to an invalid line (00) raises bus_req with bus_op READ (01). An acknowledge without retry is followed one cycle later by done with new_state exclusive (01).
- R4: An acknowledge with bus_retry high keeps bus_req asserted with the same bus_op, which reissues the operation. done never comes before an acknowledge without retry.
- R5: A store-type access (store 001, conditional store 011, block-zero 100) without write-through that hits exclusive or modified starts no bus operation. It completes the cycle after acceptance with new_state modified (10).
- R6: A store-type access without write-through to an invalid line issues RWITM (bus_op 10) and completes with new_state modified.
- R7: With req_wt high, a store-type access to a modified line issues PUSH (bus_op 11) and completes with new_state exclusive. The same access to an exclusive line completes locally as exclusive. To an invalid line it issues RWITM and completes as exclusive.
- R8: fill_way_vld is 1 exactly while a READ or RWITM is outstanding, and fill_way then carries the way index taken at acceptance. At all other times, PUSH included, fill_way_vld and fill_way are 0.
- R9: req_ready is 1 only while no access is in flight. Requests and line_state presented while req_ready is 0 have no effect on bus_op, new_state or resv_valid.
- R10: done and state_we are one-cycle pulses raised together, and new_state is 00 whenever done is 0.
- R11: resv_valid is set on the done cycle of a load-with-reserve, which shows one cycle later. It is cleared one cycle after a conditional store or block-zero is accepted. Plain loads and stores leave it unchanged.
- R12: line_state 11 is treated as invalid, the same as 00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Access request present |
| req_op | input | 3 | Access kind: 000 load, 001 store, 010 load-reserve, 011 conditional store, 100 block-zero |
| req_wt | input | 1 | Page is write-through |
| req_way | input | WAY_W (2) | Way chosen for refill by the replacement logic |
| line_state | input | 2 | Current line state: 00 I, 01 E, 10 M |
| req_ready | output | 1 | Block can accept an access |
| bus_req | output | 1 | Bus operation outstanding |
| bus_op | output | 2 | 00 none, 01 READ, 10 RWITM, 11 PUSH |
| bus_ack | input | 1 | Bus completes the current address tenure |
| bus_retry | input | 1 | Address retry, sampled with bus_ack |
| fill_way_vld | output | 1 | fill_way is meaningful |
| fill_way | output | WAY_W (2) | Way being refilled, binary |
| done | output | 1 | Access finished this cycle |
| state_we | output | 1 | Write new_state to the tag |
| new_state | output | 2 | Final line state |
| resv_valid | output | 1 | Reservation flag |

## Verification
A wrong decision latched at acceptance shows up one cycle later on the port. Either bus_req rises when the access should have completed, or done rises where a bus request was due. A wrong final state only becomes visible on new_state during the done pulse. A wrong reservation update appears on resv_valid one cycle after the access is accepted or finished. A retry that is not handled correctly either drops bus_req or raises done early, on the cycle after the retried acknowledge. For these reasons the reference model is compared against every output on every cycle.

// File: rtl/mei_pkg.sv
package mei_pkg;

  typedef enum logic [1:0] {
    LS_I = 2'b00,
    LS_E = 2'b01,
    LS_M = 2'b10,
    LS_X = 2'b11
  } lstate_t;

  typedef enum logic [1:0] {
    BOP_NONE  = 2'b00,
    BOP_READ  = 2'b01,
    BOP_RWITM = 2'b10,
    BOP_PUSH  = 2'b11
  } bus_op_t;

  typedef enum logic [2:0] {
    ACC_LOAD  = 3'b000,
    ACC_STORE = 3'b001,
    ACC_LRES  = 3'b010,
    ACC_SCOND = 3'b011,
    ACC_BZERO = 3'b100
  } acc_t;

  typedef enum logic [1:0] {
    PH_IDLE = 2'b00,
    PH_BUS  = 2'b01,
    PH_FIN  = 2'b10
  } phase_t;

  function automatic logic acc_writes(input logic [2:0] op);
    return (op == ACC_STORE) || (op == ACC_SCOND) || (op == ACC_BZERO);
  endfunction

  function automatic logic line_hit(input lstate_t st);
    return (st == LS_E) || (st == LS_M);
  endfunction

  // Bus action demanded by an access on a line in state st.
  function automatic bus_op_t pick_bus(input logic [2:0] op, input logic wt,
                                       input lstate_t st);
    if (!line_hit(st))
      return acc_writes(op) ? BOP_RWITM : BOP_READ;
    if (acc_writes(op) && wt && st == LS_M)
      return BOP_PUSH;
    return BOP_NONE;
  endfunction

  // State the line holds once the access has finished.
  function automatic lstate_t end_state(input logic [2:0] op, input logic wt,
                                        input lstate_t st);
    if (acc_writes(op))
      return wt ? LS_E : LS_M;
    return line_hit(st) ? st : LS_E;
  endfunction

  function automatic logic fills_line(input bus_op_t b);
    return (b == BOP_READ) || (b == BOP_RWITM);
  endfunction

endpackage

// File: rtl/mei_decide.sv
module mei_decide
  import mei_pkg::*;
(
  input  logic [2:0] op,
  input  logic       wt,
  input  lstate_t    st,
  output bus_op_t    bop,
  output lstate_t    nst
);
  always_comb begin
    bop = pick_bus(op, wt, st);
    nst = end_state(op, wt, st);
  end

  // R7: a write-through access never leaves a line modified
  always_comb begin
    if (acc_writes(op) && wt)
      a_r7_wt_not_mod: assert (nst != LS_M);
  end
endmodule

// File: rtl/mei_seq.sv
module mei_seq
  import mei_pkg::*;
#(
  parameter int WAY_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  bus_op_t          bop_d,
  input  lstate_t          nst_d,
  input  logic [WAY_W-1:0] way_d,
  input  logic             bus_ack,
  input  logic             bus_retry,
  output logic             ready,
  output logic             accept,
  output logic             bus_req,
  output bus_op_t          bus_op,
  output logic             fill_vld,
  output logic [WAY_W-1:0] fill_way,
  output logic             fin
);
  phase_t           ph;
  bus_op_t          bop_q;
  lstate_t          nst_q;
  logic [WAY_W-1:0] way_q;

  logic bus_clean;
  logic bus_redo;
  assign bus_clean = (ph == PH_BUS) && bus_ack && !bus_retry;
  assign bus_redo  = (ph == PH_BUS) && bus_ack && bus_retry;

  assign ready  = (ph == PH_IDLE);
  assign accept = ready && req_valid;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph    <= PH_IDLE;
      bop_q <= BOP_NONE;
      nst_q <= LS_I;
      way_q <= '0;
    end else begin
      unique case (ph)
        PH_IDLE: if (accept) begin
          bop_q <= bop_d;
          nst_q <= nst_d;
          way_q <= way_d;
          ph    <= (bop_d == BOP_NONE) ? PH_FIN : PH_BUS;
        end
        PH_BUS:  if (bus_clean) ph <= PH_FIN;
        default: ph <= PH_IDLE;
      endcase
    end
  end

  assign bus_req  = (ph == PH_BUS);
  assign bus_op   = bus_req ? bop_q : BOP_NONE;
  assign fill_vld = bus_req && fills_line(bop_q);
  assign fill_way = fill_vld ? way_q : '0;
  assign fin      = (ph == PH_FIN);

  lstate_t fin_state;
  assign fin_state = nst_q;

  // R4: a retried or pending operation keeps the same request
  a_r4_hold_op: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !bus_clean) |=> (bus_req && $stable(bus_op)));
  // R3: clean acknowledge finishes on the next cycle
  a_r3_ack_done: assert property (@(posedge clk) disable iff (!rst_n)
    bus_clean |=> fin);
  // R2: a local hit finishes the cycle after acceptance
  a_r2_local: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && bop_d == BOP_NONE) |=> (fin && !bus_req));
  // R9: no acceptance while busy
  a_r9_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req || fin) |-> !ready);
  // R8: way index only during a fill
  a_r8_way_fill: assert property (@(posedge clk) disable iff (!rst_n)
    fill_vld |-> (bus_req && bus_op != BOP_PUSH));
  // R10: completion is a single pulse
  a_r10_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    fin |=> !fin);
  // R4: redo never finishes on its own cycle
  a_r4_redo: assert property (@(posedge clk) disable iff (!rst_n)
    bus_redo |=> !fin);
  // R10: finishing state is never the reserved encoding
  a_r10_state: assert property (@(posedge clk) disable iff (!rst_n)
    fin |-> (fin_state != LS_X && fin_state != LS_I));
endmodule

// File: rtl/mei_resv.sv
module mei_resv
  import mei_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       accept,
  input  logic [2:0] op,
  input  logic       fin,
  output logic       resv
);
  logic lres_pend;
  logic kill_ev;
  logic set_ev;

  assign kill_ev = accept && (op == ACC_SCOND || op == ACC_BZERO);
  assign set_ev  = fin && lres_pend;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      resv      <= 1'b0;
      lres_pend <= 1'b0;
    end else begin
      if (accept) lres_pend <= (op == ACC_LRES);
      if (kill_ev)     resv <= 1'b0;
      else if (set_ev) resv <= 1'b1;
    end
  end

  // R11: conditional store and block-zero drop the reservation
  a_r11_clear: assert property (@(posedge clk) disable iff (!rst_n)
    kill_ev |=> !resv);
  // R11: load-reserve completion sets it
  a_r11_set: assert property (@(posedge clk) disable iff (!rst_n)
    set_ev |=> resv);
  // R11: flag moves only on those events
  a_r11_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (!kill_ev && !set_ev) |=> $stable(resv));
endmodule

// File: rtl/mei_ls_ctrl.sv
module mei_ls_ctrl
  import mei_pkg::*;
#(
  parameter  int NUM_WAYS = 4,
  localparam int WAY_W    = (NUM_WAYS > 1) ? $clog2(NUM_WAYS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic [2:0]       req_op,
  input  logic             req_wt,
  input  logic [WAY_W-1:0] req_way,
  input  logic [1:0]       line_state,
  output logic             req_ready,
  output logic             bus_req,
  output logic [1:0]       bus_op,
  input  logic             bus_ack,
  input  logic             bus_retry,
  output logic             fill_way_vld,
  output logic [WAY_W-1:0] fill_way,
  output logic             done,
  output logic             state_we,
  output logic [1:0]       new_state,
  output logic             resv_valid
);
  bus_op_t bop_d, bop_o;
  lstate_t nst_d, nst_q;
  logic    accept, fin;

  mei_decide u_dec (
    .op  (req_op),
    .wt  (req_wt),
    .st  (lstate_t'(line_state)),
    .bop (bop_d),
    .nst (nst_d)
  );

  mei_seq #(.WAY_W(WAY_W)) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_valid(req_valid),
    .bop_d    (bop_d),
    .nst_d    (nst_d),
    .way_d    (req_way),
    .bus_ack  (bus_ack),
    .bus_retry(bus_retry),
    .ready    (req_ready),
    .accept   (accept),
    .bus_req  (bus_req),
    .bus_op   (bop_o),
    .fill_vld (fill_way_vld),
    .fill_way (fill_way),
    .fin      (fin)
  );

  mei_resv u_resv (
    .clk   (clk),
    .rst_n (rst_n),
    .accept(accept),
    .op    (req_op),
    .fin   (fin),
    .resv  (resv_valid)
  );

  // final state held for the done pulse
  always_ff @(posedge clk) begin
    if (!rst_n)      nst_q <= LS_I;
    else if (accept) nst_q <= nst_d;
  end

  assign bus_op    = bop_o;
  assign done      = fin;
  assign state_we  = fin;
  assign new_state = fin ? nst_q : LS_I;
endmodule

// File: tb/tb_mei_ls_ctrl.sv
module tb_mei_ls_ctrl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       req_valid = 1'b0;
  logic [2:0] req_op = 3'd0;
  logic       req_wt = 1'b0;
  logic [1:0] req_way = 2'd0;
  logic [1:0] line_state = 2'd0;
  logic       bus_ack = 1'b0, bus_retry = 1'b0;
  logic       req_ready, bus_req, fill_way_vld, done, state_we, resv_valid;
  logic [1:0] bus_op, fill_way, new_state;

  always #2 clk = ~clk;

  mei_ls_ctrl dut (.*);

  int    n_chk = 0, n_bad = 0;
  string cur_tag = "R1";
  bit    reported = 0;

  // behavioural reference
  int ph = 0, m_bop = 0, m_nst = 0, m_way = 0;
  bit m_lres = 0, m_resv = 0;

  function automatic bit is_wr(int op);
    return op == 1 || op == 3 || op == 4;
  endfunction
  function automatic int want_bus(int op, bit wt, int st);
    bit hit = (st == 1 || st == 2);
    if (!hit) return is_wr(op) ? 2 : 1;
    return (is_wr(op) && wt && st == 2) ? 3 : 0;
  endfunction
  function automatic int want_state(int op, bit wt, int st);
    if (is_wr(op)) return wt ? 1 : 2;
    return (st == 1 || st == 2) ? st : 1;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      ph = 0; m_resv = 0; m_lres = 0;
    end else begin
      case (ph)
        0: if (req_valid) begin
          m_bop  = want_bus(req_op, req_wt, line_state);
          m_nst  = want_state(req_op, req_wt, line_state);
          m_way  = req_way;
          m_lres = (req_op == 2);
          if (req_op == 3 || req_op == 4) m_resv = 0;
          ph = (m_bop == 0) ? 2 : 1;
        end
        1: if (bus_ack && !bus_retry) ph = 2;
        default: begin
          if (m_lres) m_resv = 1;
          ph = 0;
        end
      endcase
    end
  end

  task automatic chk(string tag, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      chk("R9", "req_ready", req_ready, ph == 0);
      chk(cur_tag, "bus_req", bus_req, ph == 1);
      chk(cur_tag, "bus_op", bus_op, ph == 1 ? m_bop : 0);
      chk("R8", "fill_way_vld", fill_way_vld, ph == 1 && (m_bop == 1 || m_bop == 2));
      chk("R8", "fill_way", fill_way, (ph == 1 && (m_bop == 1 || m_bop == 2)) ? m_way : 0);
      chk("R10", "done", done, ph == 2);
      chk("R10", "state_we", state_we, ph == 2);
      chk(cur_tag, "new_state", new_state, ph == 2 ? m_nst : 0);
      chk("R11", "resv_valid", resv_valid, m_resv);
    end
  end

  // bus responder
  int rsp_wait = 0, rsp_delay = 0, rsp_retries = 0;
  always @(negedge clk) begin
    if (bus_req) begin
      if (rsp_wait > 0) begin
        rsp_wait--; bus_ack = 0; bus_retry = 0;
      end else begin
        bus_ack = 1;
        bus_retry = (rsp_retries > 0);
        if (rsp_retries > 0) begin
          rsp_retries--; rsp_wait = rsp_delay;
        end
      end
    end else begin
      bus_ack = 0; bus_retry = 0;
    end
  end

  task automatic access(int op, bit wt, int st, int way, int retries, int dly, string tag);
    @(negedge clk);
    cur_tag = tag;
    rsp_retries = retries; rsp_delay = dly; rsp_wait = dly;
    req_valid = 1; req_op = op[2:0]; req_wt = wt; line_state = st[1:0]; req_way = way[1:0];
    @(negedge clk);
    // R9: junk presented while busy must have no effect
    req_op = 3'd3; line_state = 2'd2; req_wt = ~wt; req_way = ~way[1:0];
    while (!done) @(negedge clk);
    req_valid = 0;
  endtask

  task automatic report();
    if (!reported) begin
      reported = 1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  endtask

  initial begin
    #20000;
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    report();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1", "ready after reset", req_ready, 1);
    chk("R1", "resv after reset", resv_valid, 0);
    chk("R1", "new_state after reset", new_state, 0);
    access(0, 0, 1, 0, 0, 0, "R2");
    access(0, 0, 2, 1, 0, 0, "R2");
    access(0, 0, 0, 2, 0, 0, "R3");
    access(0, 0, 0, 3, 0, 3, "R3");
    access(0, 0, 0, 1, 2, 1, "R4");
    access(1, 0, 2, 0, 0, 0, "R5");
    access(1, 0, 1, 0, 0, 0, "R5");
    access(1, 0, 0, 2, 0, 2, "R6");
    access(1, 0, 0, 3, 3, 0, "R4");
    access(1, 1, 2, 1, 0, 1, "R7");
    access(1, 1, 2, 1, 1, 0, "R7");
    access(1, 1, 1, 0, 0, 0, "R7");
    access(1, 1, 0, 2, 0, 0, "R7");
    access(0, 0, 3, 1, 0, 0, "R12");
    access(1, 0, 3, 2, 0, 0, "R12");
    access(2, 0, 0, 1, 1, 0, "R11");
    access(0, 0, 1, 0, 0, 0, "R11");
    access(1, 0, 2, 0, 0, 0, "R11");
    access(3, 0, 1, 0, 0, 0, "R11");
    access(2, 0, 2, 0, 0, 0, "R11");
    access(4, 0, 0, 3, 0, 1, "R11");
    access(2, 0, 1, 0, 0, 0, "R11");
    access(4, 1, 2, 0, 0, 0, "R11");
    for (int i = 0; i < 40; i++)
      access(i % 5, (i / 5) % 2, (i * 7) % 4, (i * 3) % 4, i % 3, (i * 5) % 3, "R9");
    repeat (3) @(negedge clk);
    report();
  end
endmodule